// File: doc/BRIEF.md
# Retimed Modulo-N Wrap Counter

This block keeps an iteration index that steps through 0, 1, ..., N-1 and then returns to 0, advancing once for every cycle in which the advance strobe is high. Its output matches a plain single-register wrap counter value for value. Internally, the add-compare-clear loop does not close in one cycle. Two lane registers each step by two modulo N, and they take turns driving the output. Each lane also keeps a precomputed successor in its own register. As a result, the only path from a lane's value back to itself crosses two flops, and the wrap arithmetic has a whole cycle to settle.

A start value can be loaded at any time. A legal value lies in 0..N-1. The load re-seeds both lanes together: one lane takes the value and the other takes its successor. The turn flop then returns to the first lane. A load value of N or more cannot be represented in the split form. Such a load is refused, and a one-cycle error flag reports it. The modulus is a constant parameter with a default of 256; odd moduli and N = 1 are supported. Reset is asynchronous and active low, and its release is synchronised to the clock. Reset has the same effect as loading 0.

Top module: `modn_split_counter`

## Requirements
- R1: While reset is asserted, and after its release until the first advance or load, `count_o` is 0 and `load_err_o` is 0.
- R2: With `load_i` low, a clock edge that sees `adv_i` high raises `count_o` by one, visible right after that edge, whenever the old value is below N-1.
- R3: With `load_i` low, an advance from N-1 gives 0. With N = 1 the count stays 0.
- R4: With `adv_i` and `load_i` both low, `count_o` keeps its value across the edge.
- R5: When `load_i` is high and `load_val_i` is below N, `count_o` equals `load_val_i` after the edge, whatever `adv_i` is in that cycle. Load has priority over advance.
- R6: When `load_i` is high and `load_val_i` is N or more, the load is refused and `load_err_o` is 1 for exactly the following cycle. The count behaves as if `load_i` were low, so it advances if `adv_i` is high and holds otherwise.
- R7: `load_err_o` is 0 in every cycle that does not follow a refused load.
- R8: For any pattern of advances, loads and resets, the sequence on `count_o` is identical to a single-register counter that adds one and clears on reaching N. The two lanes always differ by exactly one modulo N, with the non-driving lane one step ahead.
- R9: `count_o` never reaches N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised inside |
| adv_i | input | 1 | Advance the count by one on this edge |
| load_i | input | 1 | Request to load `load_val_i` as the new count |
| load_val_i | input | CNT_W+1 | Start value; one bit wider than the count so that out-of-range values can be presented |
| count_o | output | CNT_W | Current iteration index, 0..N-1 |
| load_err_o | output | 1 | High for one cycle after a refused (out-of-range) load |

## Verification
The hardest cases to reach from the ports involve loads and the turn flop. One is a load that arrives while the odd lane is driving. Another is a load, or a refused load, that coincides with an advance. A third is a lane that is stepped on the cycle right after it was seeded, before its precomputed successor has been refreshed from the feedback path. The bench reaches these cases with three kinds of stimulus: dense random advance patterns with frequent loads, directed load-with-advance cycles including a load of N-1 followed at once by a wrap, and a reset in the middle of the run. Four instances with N = 256, 7, 1 and 2 run the same stimulus, so power-of-two, odd and degenerate moduli are all covered. A behavioural reference counter checks each instance on every clock.

// File: rtl/modn_split_pkg.sv
package modn_split_pkg;

  // Which lane currently drives the count.
  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  // Width of the count for modulus n (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // True when n is a power of two (natural binary wrap suffices).
  function automatic bit is_pow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/modn_split_rst_sync.sv
module modn_split_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/modn_split_gate.sv
module modn_split_gate #(
  parameter int unsigned MOD_N = 256,
  parameter int unsigned CNT_W = modn_split_pkg::cnt_width(MOD_N),
  parameter int unsigned LD_W  = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LD_W-1:0]  load_val_i,
  output logic             seed_en_o,
  output logic [CNT_W-1:0] seed_val_o,
  output logic             load_err_o
);

  localparam logic [LD_W-1:0] N_LD = LD_W'(MOD_N);

  logic in_range;
  logic err_d;
  logic err_q;

  always_comb begin
    in_range   = (load_val_i < N_LD);
    seed_en_o  = load_i & in_range;
    seed_val_o = load_val_i[CNT_W-1:0];
    err_d      = load_i & ~in_range;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign load_err_o = err_q;

endmodule

// File: rtl/modn_split_lane.sv
module modn_split_lane #(
  parameter int unsigned MOD_N    = 256,
  parameter int unsigned CNT_W    = modn_split_pkg::cnt_width(MOD_N),
  parameter int unsigned SEED_OFS = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_en_i,
  input  logic [CNT_W-1:0] seed_val_i,
  input  logic             step_en_i,
  output logic [CNT_W-1:0] val_o
);

  localparam logic [CNT_W:0]   N_X     = (CNT_W+1)'(MOD_N);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(SEED_OFS % MOD_N);
  localparam logic [CNT_W-1:0] RST_NXT = CNT_W'((SEED_OFS + 2) % MOD_N);
  localparam bit               IS_P2   = modn_split_pkg::is_pow2(MOD_N);

  // Seed-path helper: add a small increment and wrap (off the feedback loop).
  function automatic logic [CNT_W-1:0] wrap_add(input logic [CNT_W-1:0] v,
                                                input int unsigned inc);
    logic [CNT_W:0] s;
    s = {1'b0, v} + (CNT_W+1)'(inc);
    if (s >= N_X) s = s - N_X;
    if (s >= N_X) s = s - N_X;
    return s[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] val_d;
  logic [CNT_W-1:0] nxt_q;
  logic [CNT_W-1:0] nxt_d;
  logic [CNT_W-1:0] fb_sum;
  logic [CNT_W-1:0] seeded;
  logic             val_en;

  // Feedback arithmetic: value plus two, wrapped. Registered into nxt_q,
  // so the loop val_q -> nxt_q -> val_q spans two flops.
  generate
    if (IS_P2) begin : g_fb_pow2
      always_comb begin
        fb_sum = val_q + CNT_W'(2);
      end
    end else begin : g_fb_cmp
      logic [CNT_W:0] raw;
      logic [CNT_W:0] raw_sub;
      always_comb begin
        raw     = {1'b0, val_q} + (CNT_W+1)'(2);
        raw_sub = raw - N_X;
        fb_sum  = (raw >= N_X) ? raw_sub[CNT_W-1:0] : raw[CNT_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    seeded = wrap_add(seed_val_i, SEED_OFS);
    val_en = seed_en_i | step_en_i;
    val_d  = val_q;
    nxt_d  = fb_sum;
    if (seed_en_i) begin
      val_d = seeded;
      nxt_d = wrap_add(seeded, 2);
    end else if (step_en_i) begin
      val_d = nxt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= RST_VAL;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= RST_NXT;
    end else begin
      nxt_q <= nxt_d;
    end
  end

  assign val_o = val_q;

endmodule

// File: rtl/modn_split_counter.sv
module modn_split_counter #(
  parameter int unsigned MOD_N = 256,
  parameter int unsigned CNT_W = modn_split_pkg::cnt_width(MOD_N),
  parameter int unsigned LD_W  = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [LD_W-1:0]  load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             load_err_o
);

  import modn_split_pkg::*;

  localparam int unsigned LANES = 2;

  logic                          rst_n_q;
  logic                          seed_en;
  logic [CNT_W-1:0]              seed_val;
  phase_e                        phase_q;
  phase_e                        phase_d;
  logic [LANES-1:0]              step_en;
  logic [LANES-1:0][CNT_W-1:0]   lane_val;

  modn_split_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  modn_split_gate #(
    .MOD_N (MOD_N),
    .CNT_W (CNT_W),
    .LD_W  (LD_W)
  ) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_q),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .seed_en_o  (seed_en),
    .seed_val_o (seed_val),
    .load_err_o (load_err_o)
  );

  // Turn flop: re-seed returns to the even lane, advance alternates.
  always_comb begin
    phase_d = phase_q;
    if (seed_en) begin
      phase_d = PH_EVEN;
    end else if (adv_i) begin
      phase_d = (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      phase_q <= PH_EVEN;
    end else begin
      phase_q <= phase_d;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
        step_en[g] = adv_i & ~seed_en & (phase_q == phase_e'(g));
      end

      modn_split_lane #(
        .MOD_N    (MOD_N),
        .CNT_W    (CNT_W),
        .SEED_OFS (g)
      ) u_lane (
        .clk_i      (clk_i),
        .rst_ni     (rst_n_q),
        .seed_en_i  (seed_en),
        .seed_val_i (seed_val),
        .step_en_i  (step_en[g]),
        .val_o      (lane_val[g])
      );
    end
  endgenerate

  always_comb begin
    count_o = (phase_q == PH_ODD) ? lane_val[1] : lane_val[0];
  end

endmodule

// File: rtl/modn_split_chk.sv
module modn_split_chk #(
  parameter int unsigned MOD_N = 256,
  parameter int unsigned CNT_W = modn_split_pkg::cnt_width(MOD_N),
  parameter int unsigned LD_W  = CNT_W + 1
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             adv_i,
  input logic             load_i,
  input logic [LD_W-1:0]  load_val_i,
  input logic [CNT_W-1:0] count_o,
  input logic             load_err_o,
  input logic             phase_odd,
  input logic [CNT_W-1:0] even_val,
  input logic [CNT_W-1:0] odd_val
);

  localparam logic [CNT_W-1:0] TOP_V = CNT_W'(MOD_N - 1);
  localparam logic [CNT_W:0]   N_C   = (CNT_W+1)'(MOD_N);
  localparam logic [LD_W-1:0]  N_L   = LD_W'(MOD_N);

  logic ld_ok;
  logic ld_bad;
  assign ld_ok  = load_i && (load_val_i <  N_L);
  assign ld_bad = load_i && (load_val_i >= N_L);

  // R9: count stays inside 0..N-1
  assert_count_range_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    {1'b0, count_o} < N_C);

  // R4: idle cycle holds the count
  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(count_o));

  // R2, R3: advance adds one, wrapping from N-1 to 0
  assert_step_wrap_R2_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adv_i && !load_i) |=>
      (count_o == (($past(count_o) == TOP_V) ? '0 : $past(count_o) + 1'b1)));

  // R5: a legal load wins over advance
  assert_load_take_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld_ok |=> (count_o == $past(load_val_i[CNT_W-1:0])));

  // R6: refused load raises the flag next cycle
  assert_reject_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld_bad |=> load_err_o);

  // R7: flag quiet otherwise
  assert_flag_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ld_bad |=> !load_err_o);

  // R8: idle lane always sits one step ahead of the driving lane
  assert_lane_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !phase_odd |-> (odd_val == ((even_val == TOP_V) ? '0 : even_val + 1'b1)));

  assert_lane_pair_odd_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    phase_odd |-> (even_val == ((odd_val == TOP_V) ? '0 : odd_val + 1'b1)));

endmodule

bind modn_split_counter modn_split_chk #(
  .MOD_N (MOD_N),
  .CNT_W (CNT_W),
  .LD_W  (LD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_q),
  .adv_i      (adv_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .count_o    (count_o),
  .load_err_o (load_err_o),
  .phase_odd  (phase_q == modn_split_pkg::PH_ODD),
  .even_val   (lane_val[0]),
  .odd_val    (lane_val[1])
);

// File: tb/tb_modn_split_counter.sv
`timescale 1ns/1ps
module tb_modn_split_counter;

  localparam int NUM = 4;
  localparam int NS  [NUM] = '{256, 7, 1, 2};
  localparam int LWS [NUM] = '{9, 4, 2, 2};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       adv;
  logic       ld;
  logic [8:0] lv;

  logic [7:0] c0;
  logic [2:0] c1;
  logic [0:0] c2;
  logic [0:0] c3;
  logic       e0, e1, e2, e3;

  always #2 clk = ~clk;

  modn_split_counter #(.MOD_N(256)) dut (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .load_i(ld),
    .load_val_i(lv), .count_o(c0), .load_err_o(e0));

  modn_split_counter #(.MOD_N(7)) dut_n7 (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .load_i(ld),
    .load_val_i(lv[3:0]), .count_o(c1), .load_err_o(e1));

  modn_split_counter #(.MOD_N(1)) dut_n1 (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .load_i(ld),
    .load_val_i(lv[1:0]), .count_o(c2), .load_err_o(e2));

  modn_split_counter #(.MOD_N(2)) dut_n2 (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .load_i(ld),
    .load_val_i(lv[1:0]), .count_o(c3), .load_err_o(e3));

  int    act_cnt [NUM];
  int    act_err [NUM];
  int    exp_cnt [NUM];
  int    exp_err [NUM];
  string exp_tag [NUM];
  int    compared   = 0;
  int    mismatched = 0;
  bit    started    = 1'b0;

  always_comb begin
    act_cnt[0] = int'(c0); act_err[0] = int'(e0);
    act_cnt[1] = int'(c1); act_err[1] = int'(e1);
    act_cnt[2] = int'(c2); act_err[2] = int'(e2);
    act_cnt[3] = int'(c3); act_err[3] = int'(e3);
  end

  // Behavioural reference: one plain counter per modulus.
  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < NUM; k++) begin
      int    lvk;
      int    nc;
      string tg;
      lvk = int'(lv) % (1 << LWS[k]);
      if (!rst_n) begin
        exp_cnt[k] <= 0;
        exp_err[k] <= 0;
        exp_tag[k] <= "R1";
      end else begin
        nc = exp_cnt[k];
        tg = "R4";
        if (ld && lvk < NS[k]) begin
          nc = lvk;
          tg = "R5";
        end else begin
          if (adv) begin
            nc = (nc + 1) % NS[k];
            tg = (nc == 0) ? "R3" : "R2";
          end
          if (ld) tg = "R6";
        end
        exp_cnt[k] <= nc;
        exp_err[k] <= (ld && lvk >= NS[k]) ? 1 : 0;
        exp_tag[k] <= tg;
      end
    end
  end

  task automatic check(input string tag, input string what, input int k,
                       input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s N=%0d %s: actual %0d expected %0d at %0t",
               tag, NS[k], what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      for (int k = 0; k < NUM; k++) begin
        check({exp_tag[k], " R8"}, "count", k, act_cnt[k], exp_cnt[k]);
        check((exp_err[k] != 0) ? "R6" : "R7", "load_err", k,
              act_err[k], exp_err[k]);
        check("R9", "count<N", k, (act_cnt[k] < NS[k]) ? 1 : 0, 1);
      end
    end
  end

  task automatic drive(input bit a, input bit l, input logic [8:0] v);
    @(negedge clk);
    #1;
    adv = a;
    ld  = l;
    lv  = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    adv = 1'b0; ld = 1'b0; lv = '0;
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) drive(1'b0, 1'b0, 9'd0);
  endtask

  task automatic random_run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      logic [8:0] v;
      v = ($urandom % 2 != 0) ? 9'($urandom % 8) : 9'($urandom % 512);
      drive(($urandom % 4) != 0, ($urandom % 10) == 0, v);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R8 watchdog: actual running expected finished at %0t", $time);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; adv = 1'b0; ld = 1'b0; lv = '0;
    @(posedge clk);
    started = 1'b1;
    repeat (3) @(negedge clk);   // R1: reset state compared here
    #1;
    rst_n = 1'b1;
    repeat (4) drive(1'b0, 1'b0, 9'd0);

    // R2, R3: continuous advance wraps the 256 counter twice
    repeat (600) drive(1'b1, 1'b0, 9'd0);

    // R5, R6: directed loads, alone and together with advance
    drive(1'b0, 1'b1, 9'd6);
    drive(1'b1, 1'b0, 9'd0);
    drive(1'b1, 1'b1, 9'd255);   // legal for 256, refused for 7
    drive(1'b1, 1'b0, 9'd0);     // R3: 255 -> 0 right after seeding
    drive(1'b1, 1'b1, 9'd300);   // refused everywhere except masked widths
    drive(1'b0, 1'b0, 9'd0);
    drive(1'b0, 1'b1, 9'd5);
    drive(1'b1, 1'b1, 9'd3);     // load on odd turn? no: checks priority
    drive(1'b1, 1'b0, 9'd0);
    drive(1'b1, 1'b1, 9'd1);     // load while odd lane drives
    repeat (3) drive(1'b1, 1'b0, 9'd0);
    drive(1'b0, 1'b1, 9'd6);     // R5 boundary N-1 for N=7
    drive(1'b1, 1'b0, 9'd0);
    drive(1'b0, 1'b1, 9'd7);     // R6 boundary N for N=7
    drive(1'b0, 1'b0, 9'd0);     // R4 hold after refused load

    // R8: dense random patterns
    random_run(3000);

    // R1: reset in the middle of a run
    do_reset();
    random_run(400);

    repeat (4) drive(1'b0, 1'b0, 9'd0);
    finish_run();
  end

endmodule